// File: doc/BRIEF.md
# Frame-Synchronised Precision Time Counter

This block keeps a precision time-of-day for a timing endpoint that runs from a 125 MHz reference. Each reference cycle adds a programmable increment to two counters. One is a seconds/nanoseconds time-of-day that wraps nanoseconds into seconds. The other is a free-running 48-bit nanosecond counter. The increment is a 32-bit word with 28 fractional bits, so the value 0x8000_0000 advances the counters by exactly 8 ns. Smaller steps of the fractional part accumulate without drift, which lets software apply small frequency corrections.

Software reaches the block through a simple 16-bit register bus. New time values and a new frequency word are written into shadow registers first. They take effect together on the next frame-sync event. A frame sync comes either from a rising edge of a software-controlled bit or from a rising edge on an external sync input. The same event can latch the current time-of-day into capture registers and raise an interrupt flag, so software can read a consistent timestamp afterwards with a start/end strobe pair.

Top module: `ptp_nco_clock`

## Requirements
- R1: After a synchronous active-high reset, both counters, the interrupt flag, all registers, `bus_rdata` and `bus_rvalid` are zero.
- R2: The counters advance and frame syncs are accepted only while both control bits 15 and 14 are 1. Otherwise the counters hold their value.
- R3: While running, each cycle adds the increment to both counters. When the frequency-select bit (bit 14 of the NCO-word-2 register) is 0, the increment is the nominal 0x8000_0000, which is 8 ns.
- R4: When the time-of-day nanoseconds reach 1,000,000,000, they wrap by that amount and the seconds count rises by one in the same cycle.
- R5: A frame sync fires on a 0-to-1 change of control bit 5. It also fires on a rising edge of `ext_sync`, seen through a two-stage synchroniser, but only when control bit 3 is set. Holding either source high does not fire again.
- R6: If load-select bit 10 is set and control bit 12 (init) is set at the frame sync, the time-of-day takes the shadowed time: nanoseconds from words TC0 (low) and TC1 (high), seconds from TC2, TC3 and TC4 (low to high). The fraction clears. After such a sync, load-select bits 10 and 7 clear themselves. Without init, nothing is loaded and the bits stay set.
- R7: Under the same init condition, load-select bit 7 loads the nanosecond counter with {NCO2[11:0], NCO1, NCO0, 4'b0000}.
- R8: Load-select bit 6 copies the shadow frequency word {FREQ_HI, FREQ_LO} into the active word at any frame sync, with or without init. Bit 6 does not clear itself. The active word takes effect only while the frequency-select bit is 1. Its bits 31:28 are whole nanoseconds and bits 27:0 are a fraction.
- R9: When control bit 13 is set, a frame sync latches the time-of-day present just before that edge. It also sets status bit 0, which drives `fsync_irq` from the next cycle.
- R10: Writing 1 to bit 10 of the readout-control register copies the latched capture into four readout words. These are SNAP0 (nanoseconds [15:0]), SNAP1 (nanoseconds [31:16]), SNAP2 (seconds [15:0]) and SNAP3 (seconds [31:16]). Later captures do not change them until the next start strobe. Writing 1 to bit 11 clears status bit 0.
- R11: A read request returns the addressed register on `bus_rdata` with `bus_rvalid` high in the following cycle.
- R12: Register addresses are: control 0x00, load-select 0x01, FREQ_LO 0x02, FREQ_HI 0x03, NCO0 to NCO2 0x04 to 0x06, TC0 to TC4 0x08 to 0x0C, status 0x10, readout control 0x11, SNAP0 to SNAP3 0x12 to 0x15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| ext_sync | input | 1 | Asynchronous external frame-sync input |
| tod_sec | output | 48 | Time-of-day seconds |
| tod_ns | output | 30 | Time-of-day nanoseconds |
| nco_ns | output | 48 | Free-running nanosecond counter |
| fsync_irq | output | 1 | Capture interrupt flag (status bit 0) |

## Verification
A wrong fraction or a wrong choice of increment shows on `tod_ns` within two cycles, as a step other than the expected 8 or 8.5 ns. A wrong wrap shows as a seconds value off by one at the cycle the nanoseconds reach a billion. A spurious or missed frame sync shows in three places: a time or NCO value that was or was not replaced on the cycle after the triggering write, load-select bits that should or should not have cleared, and an interrupt flag that rose or stayed low. Capture timing errors show as snapshot words that differ from the time-of-day on the cycle just before the sync edge.

// File: rtl/ptp_nco_pkg.sv
package ptp_nco_pkg;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_LOADSEL = 5'h01;
  localparam logic [ADDR_W-1:0] A_FREQ_LO = 5'h02;
  localparam logic [ADDR_W-1:0] A_FREQ_HI = 5'h03;
  localparam logic [ADDR_W-1:0] A_NCOT0   = 5'h04;
  localparam logic [ADDR_W-1:0] A_NCOT1   = 5'h05;
  localparam logic [ADDR_W-1:0] A_NCOT2   = 5'h06;
  localparam logic [ADDR_W-1:0] A_TC0     = 5'h08;
  localparam logic [ADDR_W-1:0] A_STATUS  = 5'h10;
  localparam logic [ADDR_W-1:0] A_RDCTL   = 5'h11;
  localparam logic [ADDR_W-1:0] A_SNAP0   = 5'h12;

  localparam int TC_WORDS   = 5;
  localparam int SNAP_WORDS = 4;

  // control register bit positions
  localparam int CB_RUN_HI = 15;
  localparam int CB_RUN_LO = 14;
  localparam int CB_CAPEN  = 13;
  localparam int CB_INIT   = 12;
  localparam int CB_CPU    = 5;
  localparam int CB_EXT    = 3;

  // load-select bit positions
  localparam int LB_TC   = 10;
  localparam int LB_NCOT = 7;
  localparam int LB_FREQ = 6;

  localparam int FSEL_BIT  = 14;
  localparam int RD_START  = 10;
  localparam int RD_END    = 11;

  localparam int unsigned NS_PER_SEC = 1_000_000_000;
endpackage

// File: rtl/pnc_fsync.sv
module pnc_fsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic cpu_bit,
  input  logic ext_sel,
  input  logic ext_in,
  output logic fsync
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic cpu_prev, ext_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ext_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_prev <= 1'b0;
      ext_prev <= 1'b0;
    end else begin
      cpu_prev <= cpu_bit;
      ext_prev <= sync_q[TOP];
    end
  end

  assign fsync = run & ((cpu_bit & ~cpu_prev) |
                        (ext_sel & sync_q[TOP] & ~ext_prev));
endmodule

// File: rtl/pnc_tod.sv
module pnc_tod #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int FRAC_W = 28,
  parameter int INC_W  = 32,
  parameter int unsigned WRAP_NS = 1_000_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [INC_W-1:0] inc,
  input  logic [SEC_W-1:0] ld_sec,
  input  logic [NS_W-1:0]  ld_ns,
  output logic [SEC_W-1:0] sec,
  output logic [NS_W-1:0]  ns
);
  localparam int SUM_W = NS_W + 1;
  localparam logic [SUM_W-1:0] WRAP = SUM_W'(WRAP_NS);

  logic [FRAC_W-1:0] frac;
  logic [FRAC_W:0]   fsum;
  logic [SUM_W-1:0]  nsum;

  always_comb begin
    fsum = {1'b0, frac} + {1'b0, inc[FRAC_W-1:0]};
    nsum = {1'b0, ns} + SUM_W'(inc[INC_W-1:FRAC_W]) + SUM_W'(fsum[FRAC_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec  <= '0;
      ns   <= '0;
      frac <= '0;
    end else if (load) begin
      sec  <= ld_sec;
      ns   <= ld_ns;
      frac <= '0;
    end else if (run) begin
      frac <= fsum[FRAC_W-1:0];
      if (nsum >= WRAP) begin
        ns  <= NS_W'(nsum - WRAP);
        sec <= sec + 1'b1;
      end else begin
        ns  <= nsum[NS_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pnc_nco.sv
module pnc_nco #(
  parameter int NCO_W  = 48,
  parameter int LD_W   = 44,
  parameter int FRAC_W = 28,
  parameter int INC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [INC_W-1:0] inc,
  input  logic [LD_W-1:0]  ld_val,
  output logic [NCO_W-1:0] nco_ns
);
  localparam int ACC_W = NCO_W + FRAC_W;
  localparam int SHIFT = NCO_W - LD_W;

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (load) acc <= {ld_val, {SHIFT{1'b0}}, {FRAC_W{1'b0}}};
    else if (run)  acc <= acc + ACC_W'(inc);
  end

  assign nco_ns = acc[ACC_W-1:FRAC_W];
endmodule

// File: rtl/pnc_snap.sv
module pnc_snap #(
  parameter int NS_W = 30
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fsync,
  input  logic                  cap_en,
  input  logic                  rd_start,
  input  logic                  rd_end,
  input  logic [NS_W-1:0]       ns,
  input  logic [31:0]           sec_lo,
  output logic                  status,
  output logic [3:0][15:0]      hold
);
  logic [31:0] cap_ns, cap_sec;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_ns  <= '0;
      cap_sec <= '0;
      status  <= 1'b0;
      hold    <= '0;
    end else begin
      if (fsync && cap_en) begin
        cap_ns  <= 32'(ns);
        cap_sec <= sec_lo;
        status  <= 1'b1;
      end else if (rd_end) begin
        status  <= 1'b0;
      end
      if (rd_start)
        hold <= {cap_sec[31:16], cap_sec[15:0], cap_ns[31:16], cap_ns[15:0]};
    end
  end
endmodule

// File: rtl/pnc_regs.sv
module pnc_regs
  import ptp_nco_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int LD_W  = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              fsync,
  input  logic              status,
  input  logic [3:0][15:0]  hold,
  output logic [REG_W-1:0]  ctrl,
  output logic [REG_W-1:0]  loadsel,
  output logic [31:0]       freq_act,
  output logic              freq_sel,
  output logic [LD_W-1:0]   ncot,
  output logic [NS_W-1:0]   tc_ns,
  output logic [SEC_W-1:0]  tc_sec,
  output logic              rd_start,
  output logic              rd_end
);
  logic [1:0][15:0]          freq_sh;
  logic [15:0]               ncot_w0, ncot_w1;
  logic [11:0]               ncot_w2;
  logic [TC_WORDS-1:0][15:0] tc_w;
  logic [REG_W-1:0]          rd_mux;
  logic                      init_sync;

  assign init_sync = fsync & ctrl[CB_INIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      loadsel  <= '0;
      freq_sh  <= '0;
      freq_act <= '0;
      freq_sel <= 1'b0;
      ncot_w0  <= '0;
      ncot_w1  <= '0;
      ncot_w2  <= '0;
      tc_w     <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL:    ctrl       <= bus_wdata;
          A_FREQ_LO: freq_sh[0] <= bus_wdata;
          A_FREQ_HI: freq_sh[1] <= bus_wdata;
          A_NCOT0:   ncot_w0    <= bus_wdata;
          A_NCOT1:   ncot_w1    <= bus_wdata;
          A_NCOT2: begin
            ncot_w2  <= bus_wdata[11:0];
            freq_sel <= bus_wdata[FSEL_BIT];
          end
          default: ;
        endcase
        for (int i = 0; i < TC_WORDS; i++)
          if (bus_addr == ADDR_W'(A_TC0 + ADDR_W'(i))) tc_w[i] <= bus_wdata;
      end
      // load-select: a write wins over the self-clear after an init sync
      if (bus_wr && bus_addr == A_LOADSEL) begin
        loadsel <= bus_wdata;
      end else if (init_sync) begin
        loadsel[LB_TC]   <= 1'b0;
        loadsel[LB_NCOT] <= 1'b0;
      end
      if (fsync && loadsel[LB_FREQ])
        freq_act <= {freq_sh[1], freq_sh[0]};
    end
  end

  assign rd_start = bus_wr && bus_addr == A_RDCTL && bus_wdata[RD_START];
  assign rd_end   = bus_wr && bus_addr == A_RDCTL && bus_wdata[RD_END];

  assign ncot   = LD_W'({ncot_w2, ncot_w1, ncot_w0});
  assign tc_ns  = NS_W'({tc_w[1], tc_w[0]});
  assign tc_sec = SEC_W'({tc_w[4], tc_w[3], tc_w[2]});

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:    rd_mux = ctrl;
      A_LOADSEL: rd_mux = loadsel;
      A_FREQ_LO: rd_mux = freq_sh[0];
      A_FREQ_HI: rd_mux = freq_sh[1];
      A_NCOT0:   rd_mux = ncot_w0;
      A_NCOT1:   rd_mux = ncot_w1;
      A_NCOT2:   rd_mux = {1'b0, freq_sel, 2'b00, ncot_w2};
      A_STATUS:  rd_mux = {15'd0, status};
      default: ;
    endcase
    for (int i = 0; i < TC_WORDS; i++)
      if (bus_addr == ADDR_W'(A_TC0 + ADDR_W'(i))) rd_mux = tc_w[i];
    for (int i = 0; i < SNAP_WORDS; i++)
      if (bus_addr == ADDR_W'(A_SNAP0 + ADDR_W'(i))) rd_mux = hold[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ptp_nco_clock.sv
module ptp_nco_clock
  import ptp_nco_pkg::*;
#(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 30,
  parameter int FRAC_W      = 28,
  parameter int INC_W       = 32,
  parameter int NCO_W       = 48,
  parameter int SYNC_STAGES = 2,
  parameter logic [31:0] NOMINAL_INC = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              ext_sync,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns,
  output logic [NCO_W-1:0]  nco_ns,
  output logic              fsync_irq
);
  localparam int LD_W = NCO_W - 4;

  logic [REG_W-1:0] ctrl, loadsel;
  logic [31:0]      freq_act;
  logic             freq_sel;
  logic [LD_W-1:0]  ncot;
  logic [NS_W-1:0]  tc_ns;
  logic [SEC_W-1:0] tc_sec;
  logic             rd_start, rd_end;
  logic [3:0][15:0] hold;
  logic             run, fsync, ld_tod, ld_nco;
  logic [INC_W-1:0] inc;

  assign run    = ctrl[CB_RUN_HI] & ctrl[CB_RUN_LO];
  assign ld_tod = fsync & ctrl[CB_INIT] & loadsel[LB_TC];
  assign ld_nco = fsync & ctrl[CB_INIT] & loadsel[LB_NCOT];
  assign inc    = INC_W'(freq_sel ? freq_act : NOMINAL_INC);

  pnc_regs #(.SEC_W(SEC_W), .NS_W(NS_W), .LD_W(LD_W)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .fsync(fsync), .status(fsync_irq), .hold(hold),
    .ctrl(ctrl), .loadsel(loadsel), .freq_act(freq_act), .freq_sel(freq_sel),
    .ncot(ncot), .tc_ns(tc_ns), .tc_sec(tc_sec),
    .rd_start(rd_start), .rd_end(rd_end)
  );

  pnc_fsync #(.SYNC_STAGES(SYNC_STAGES)) fsync_i (
    .clk(clk), .rst(rst), .run(run), .cpu_bit(ctrl[CB_CPU]),
    .ext_sel(ctrl[CB_EXT]), .ext_in(ext_sync), .fsync(fsync)
  );

  pnc_tod #(.SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W),
            .WRAP_NS(NS_PER_SEC)) tod_i (
    .clk(clk), .rst(rst), .run(run), .load(ld_tod), .inc(inc),
    .ld_sec(tc_sec), .ld_ns(tc_ns), .sec(tod_sec), .ns(tod_ns)
  );

  pnc_nco #(.NCO_W(NCO_W), .LD_W(LD_W), .FRAC_W(FRAC_W), .INC_W(INC_W)) nco_i (
    .clk(clk), .rst(rst), .run(run), .load(ld_nco), .inc(inc),
    .ld_val(ncot), .nco_ns(nco_ns)
  );

  pnc_snap #(.NS_W(NS_W)) snap_i (
    .clk(clk), .rst(rst), .fsync(fsync), .cap_en(ctrl[CB_CAPEN]),
    .rd_start(rd_start), .rd_end(rd_end), .ns(tod_ns),
    .sec_lo(tod_sec[31:0]), .status(fsync_irq), .hold(hold)
  );
endmodule

// File: rtl/pnc_checker.sv
module pnc_checker
  import ptp_nco_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              fsync,
  input logic              init_bit,
  input logic              cap_en,
  input logic [REG_W-1:0]  loadsel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic [SEC_W-1:0]  tod_sec,
  input logic [NS_W-1:0]   tod_ns,
  input logic              fsync_irq
);
  p_halt_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(tod_ns) && $stable(tod_sec)));

  p_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !fsync) |=> ((tod_sec == $past(tod_sec)) ||
                         ((tod_sec == $past(tod_sec) + 1'b1) && (tod_ns < NS_W'(16)))));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    fsync |=> !fsync);

  p_loadsel_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (fsync && init_bit && !(bus_wr && bus_addr == A_LOADSEL))
      |=> (!loadsel[LB_TC] && !loadsel[LB_NCOT]));

  p_status_set_r9: assert property (@(posedge clk) disable iff (rst)
    (fsync && cap_en) |=> fsync_irq);

  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
endmodule

bind ptp_nco_clock pnc_checker #(.SEC_W(SEC_W), .NS_W(NS_W)) chk_i (
  .clk(clk), .rst(rst), .run(run), .fsync(fsync),
  .init_bit(ctrl[ptp_nco_pkg::CB_INIT]), .cap_en(ctrl[ptp_nco_pkg::CB_CAPEN]),
  .loadsel(loadsel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .tod_sec(tod_sec), .tod_ns(tod_ns),
  .fsync_irq(fsync_irq)
);

// File: tb/ptp_nco_clock_tb.sv
module ptp_nco_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        ext_sync = 1'b0;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;
  logic [47:0] nco_ns;
  logic        fsync_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ptp_nco_clock dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ext_sync(ext_sync), .tod_sec(tod_sec), .tod_ns(tod_ns), .nco_ns(nco_ns),
    .fsync_irq(fsync_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected read data", 64'(bus_rdata), 64'hDEAD);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'(bus_rdata), 64'(e));
      end
    end
  end

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [29:0] n0;
    logic [47:0] s0;
    logic [31:0] n32;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 tod_ns", 64'(tod_ns), 0);
    chk("R1 tod_sec", 64'(tod_sec), 0);
    chk("R1 nco_ns", 64'(nco_ns), 0);
    chk("R1 irq", 64'(fsync_irq), 0);
    chk("R1 rvalid", 64'(bus_rvalid), 0);
    rd(5'h00, 16'h0000, "R1 R11 control after reset");

    // R2: shadows set but engine mode off
    wr(5'h08, 16'hC9D8); wr(5'h09, 16'h3B9A);
    wr(5'h0A, 16'h0005); wr(5'h0B, 16'h0000); wr(5'h0C, 16'h0001);
    wr(5'h04, 16'h1234); wr(5'h05, 16'h5678); wr(5'h06, 16'h009A);
    wr(5'h01, 16'h0480);
    wr(5'h00, 16'h1000);
    wr(5'h00, 16'h1020);
    cyc(3);
    chk("R2 halted tod_ns", 64'(tod_ns), 0);
    chk("R2 halted nco_ns", 64'(nco_ns), 0);
    rd(5'h01, 16'h0480, "R2 R12 loadsel untouched");
    rd(5'h0C, 16'h0001, "R12 TC4 readback");

    // R6/R7: init + cpu rising edge loads time and NCO
    wr(5'h00, 16'hD000);
    wr(5'h00, 16'hD020);
    cyc(1);
    chk("R6 loaded ns", 64'(tod_ns), 64'd999_999_960);
    chk("R6 loaded sec", 64'(tod_sec), 64'h0001_0000_0005);
    chk("R7 loaded nco", 64'(nco_ns), 64'h09A5_6781_2340);
    cyc(4);
    chk("R3 nominal step ns", 64'(tod_ns), 64'd999_999_992);
    cyc(1);
    chk("R4 wrap ns", 64'(tod_ns), 0);
    chk("R4 carry sec", 64'(tod_sec), 64'h0001_0000_0006);
    chk("R3 nco advance", 64'(nco_ns), 64'h09A5_6781_2368);
    rd(5'h01, 16'h0000, "R6 load bits self-cleared");

    // R5: cpu bit held high does not fire again
    wr(5'h08, 16'h0000); wr(5'h09, 16'h0000);
    wr(5'h0A, 16'h0000); wr(5'h0C, 16'h0000);
    wr(5'h01, 16'h0400);
    wr(5'h00, 16'hD020);
    cyc(2);
    chk("R5 level hold no sync", 64'(tod_sec), 64'h0001_0000_0006);

    // R6: sync without init loads nothing; bit stays
    wr(5'h00, 16'hC000);
    wr(5'h00, 16'hC020);
    cyc(2);
    chk("R6 no init no load", 64'(tod_sec), 64'h0001_0000_0006);
    rd(5'h01, 16'h0400, "R6 bit kept without init");

    // R8: frequency shadow
    wr(5'h02, 16'h0000); wr(5'h03, 16'h8800);
    wr(5'h01, 16'h0040);
    wr(5'h00, 16'hD000);
    wr(5'h00, 16'hD020);
    n0 = tod_ns;
    cyc(2);
    chk("R8 select off keeps 8ns", 64'(tod_ns), 64'(n0 + 30'd16));
    wr(5'h06, 16'h409A);
    n0 = tod_ns;
    cyc(2);
    chk("R8 8.5ns fractional step", 64'(tod_ns), 64'(n0 + 30'd17));
    rd(5'h01, 16'h0040, "R8 freq load bit persists");
    rd(5'h06, 16'h409A, "R8 select readback");

    // R9/R10: capture on cpu sync
    wr(5'h00, 16'hE000);
    wr(5'h00, 16'hE020);
    n0 = tod_ns; s0 = tod_sec;
    cyc(1);
    chk("R9 irq set", 64'(fsync_irq), 1);
    wr(5'h11, 16'h0400);
    n32 = 32'(n0);
    rd(5'h12, n32[15:0], "R10 snap ns lo");
    rd(5'h13, n32[31:16], "R10 snap ns hi");
    rd(5'h14, s0[15:0], "R10 snap sec lo");
    rd(5'h15, s0[31:16], "R10 snap sec hi");
    rd(5'h10, 16'h0001, "R9 status bit");
    wr(5'h11, 16'h0800);
    chk("R10 end clears irq", 64'(fsync_irq), 0);
    rd(5'h10, 16'h0000, "R10 status cleared");
    // a new capture without start leaves readout alone
    wr(5'h00, 16'hE000);
    wr(5'h00, 16'hE020);
    cyc(1);
    rd(5'h12, n32[15:0], "R10 readout frozen");
    wr(5'h11, 16'h0800);

    // R9: sync without capture enable leaves status low
    wr(5'h00, 16'hC000);
    wr(5'h00, 16'hC020);
    cyc(2);
    chk("R9 no capture without enable", 64'(fsync_irq), 0);

    // R5: external input ignored unless selected
    wr(5'h00, 16'hE000);
    ext_sync = 1'b1;
    cyc(5);
    chk("R5 ext ignored", 64'(fsync_irq), 0);
    ext_sync = 1'b0;
    cyc(4);
    wr(5'h00, 16'hE008);
    ext_sync = 1'b1;
    cyc(2);
    n0 = tod_ns; s0 = tod_sec;
    cyc(1);
    chk("R5 ext sync fires", 64'(fsync_irq), 1);
    wr(5'h11, 16'h0400);
    n32 = 32'(n0);
    rd(5'h12, n32[15:0], "R5 ext capture ns lo");
    rd(5'h14, s0[15:0], "R5 ext capture sec lo");
    ext_sync = 1'b0;

    // R2: engine stop freezes counters
    wr(5'h00, 16'h0000);
    n0 = tod_ns;
    cyc(3);
    chk("R2 stop freezes", 64'(tod_ns), 64'(n0));

    cyc(2);
    chk("R11 all reads returned", 64'(exp_q.size()), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule